// File: doc/BRIEF.md
# Cross-Clock Mailbox Register Pair

This block gives two ports, each running on its own clock, a way to hand single words to each other without any queue in between. There are two one-word mailboxes, one per direction. The sender posts a word into its outgoing mailbox. After a short synchronization delay the receiving side sees a new-mail flag and the posted word. The receiver reads it by pulsing a take strobe, and that clears its flag.

The two clocks may be fully asynchronous. Neither the data word nor the flag crosses on its own. Each post flips a request toggle, which is synchronized into the receiving clock. Each take flips an acknowledge toggle, which is synchronized back into the sending clock. While a word has been posted and its acknowledge has not yet come back, the sender sees a busy indication, and any further post is dropped. The data register therefore holds still whenever the receiver samples it.

Top module: `xmbox_pair`

## Requirements
- R1: After reset, a_busy, b_busy, a_mail_flag and b_mail_flag are low, and a_mail_data and b_mail_data are all zeros.
- R2: A word posted on port A while a_busy is low appears unchanged on b_mail_data with b_mail_flag high within 12 clk_b cycles, and both stay unchanged until port B takes it.
- R3: A word posted on port B while b_busy is low appears unchanged on a_mail_data with a_mail_flag high within 12 clk_a cycles.
- R4: The sender's busy output is high from the first sender clock edge after an accepted post, and it stays high for as long as the receiver's flag is high.
- R5: A post attempted while the sender is busy is ignored. The receiver gets the first word only, and no second flag follows once that word is taken.
- R6: A take while the flag is high lowers the receiver's flag at the next receiver clock edge. The sender's busy then falls within 12 sender clock cycles.
- R7: A take while the receiver's flag is low has no effect. The flag stays low, and the sender's busy stays low.
- R8: The two directions work independently. Words posted in the same cycle on both ports are both delivered with their own values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| clk_b | input | 1 | Port B clock, may be asynchronous to clk_a |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| a_post | input | 1 | Port A strobe: post a_post_data to the A-to-B mailbox |
| a_post_data | input | 36 | Word posted by port A |
| a_busy | output | 1 | A-to-B mailbox holds a word not yet acknowledged |
| a_take | input | 1 | Port A strobe: take the word in the B-to-A mailbox |
| a_mail_data | output | 36 | Word delivered to port A |
| a_mail_flag | output | 1 | New mail waiting for port A |
| b_post | input | 1 | Port B strobe: post b_post_data to the B-to-A mailbox |
| b_post_data | input | 36 | Word posted by port B |
| b_busy | output | 1 | B-to-A mailbox holds a word not yet acknowledged |
| b_take | input | 1 | Port B strobe: take the word in the A-to-B mailbox |
| b_mail_data | output | 36 | Word delivered to port B |
| b_mail_flag | output | 1 | New mail waiting for port B |

## Verification
The bench uses the default width of 36 and two synchronizer stages. It runs a 5 ns clock on port A and a 7 ns clock on port B, so the two clocks drift against each other and the request and acknowledge toggles reach the far side at varying phases. Two synchronizer stages keep each round trip under a dozen cycles. That makes room for many back-to-back handshakes in both directions and for bounded waits on every flag and busy edge. The full 36-bit width lets all-ones, all-zeros and alternating patterns expose any lane that is dropped or swapped.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int unsigned MBX_DEF_WIDTH = 36;
    localparam int unsigned MBX_DEF_SYNC  = 2;

    // A toggle handshake is pending while the two toggles disagree.
    function automatic logic toggles_differ(input logic a, input logic b);
        return a ^ b;
    endfunction
endpackage

// File: rtl/mbx_sync.sv
module mbx_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/mbx_channel.sv
module mbx_channel
    import mbx_pkg::*;
#(
    parameter int unsigned WIDTH = MBX_DEF_WIDTH,
    parameter int unsigned SYNC  = MBX_DEF_SYNC
) (
    input  logic             wclk,
    input  logic             rclk,
    input  logic             rst_n,
    input  logic             post,
    input  logic [WIDTH-1:0] post_data,
    output logic             busy,
    input  logic             take,
    output logic [WIDTH-1:0] mail_data,
    output logic             mail_flag
);
    typedef struct packed {
        logic [WIDTH-1:0] data;
        logic             req;
    } wr_state_t;

    typedef struct packed {
        logic [WIDTH-1:0] data;
        logic             seen;
        logic             ack;
    } rd_state_t;

    wr_state_t wr_d, wr_q;
    rd_state_t rd_d, rd_q;
    logic      ack_in_w;
    logic      req_in_r;

    // Request toggle into the reader domain, acknowledge toggle back.
    mbx_sync #(.STAGES(SYNC)) u_req_sync (
        .clk(rclk), .rst_n(rst_n), .d(wr_q.req), .q(req_in_r)
    );
    mbx_sync #(.STAGES(SYNC)) u_ack_sync (
        .clk(wclk), .rst_n(rst_n), .d(rd_q.ack), .q(ack_in_w)
    );

    assign busy      = toggles_differ(wr_q.req, ack_in_w);
    assign mail_flag = toggles_differ(rd_q.seen, rd_q.ack);
    assign mail_data = rd_q.data;

    // Writer domain.
    always_comb begin
        wr_d = wr_q;
        if (post && !busy) begin
            wr_d.data = post_data;
            wr_d.req  = ~wr_q.req;
        end
    end

    always_ff @(posedge wclk or negedge rst_n) begin
        if (!rst_n) wr_q <= '0;
        else        wr_q <= wr_d;
    end

    // Reader domain: the writer data is held still while the request is
    // outstanding, so capturing it on the synchronized toggle is safe.
    always_comb begin
        rd_d = rd_q;
        if (req_in_r != rd_q.seen) begin
            rd_d.data = wr_q.data;
            rd_d.seen = req_in_r;
        end
        if (take && mail_flag) begin
            rd_d.ack = ~rd_q.ack;
        end
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end
endmodule

// File: rtl/xmbox_pair.sv
module xmbox_pair
    import mbx_pkg::*;
#(
    parameter int unsigned WIDTH = MBX_DEF_WIDTH,
    parameter int unsigned SYNC  = MBX_DEF_SYNC
) (
    input  logic             clk_a,
    input  logic             clk_b,
    input  logic             rst_n,
    input  logic             a_post,
    input  logic [WIDTH-1:0] a_post_data,
    output logic             a_busy,
    input  logic             a_take,
    output logic [WIDTH-1:0] a_mail_data,
    output logic             a_mail_flag,
    input  logic             b_post,
    input  logic [WIDTH-1:0] b_post_data,
    output logic             b_busy,
    input  logic             b_take,
    output logic [WIDTH-1:0] b_mail_data,
    output logic             b_mail_flag
);
    // Port A writes, port B reads.
    mbx_channel #(.WIDTH(WIDTH), .SYNC(SYNC)) u_a_to_b (
        .wclk(clk_a), .rclk(clk_b), .rst_n(rst_n),
        .post(a_post), .post_data(a_post_data), .busy(a_busy),
        .take(b_take), .mail_data(b_mail_data), .mail_flag(b_mail_flag)
    );

    // Port B writes, port A reads.
    mbx_channel #(.WIDTH(WIDTH), .SYNC(SYNC)) u_b_to_a (
        .wclk(clk_b), .rclk(clk_a), .rst_n(rst_n),
        .post(b_post), .post_data(b_post_data), .busy(b_busy),
        .take(a_take), .mail_data(a_mail_data), .mail_flag(a_mail_flag)
    );
endmodule

// File: rtl/xmbox_pair_chk.sv
module xmbox_pair_chk #(
    parameter int unsigned WIDTH = 36
) (
    input logic             clk_a,
    input logic             clk_b,
    input logic             rst_n,
    input logic             a_post,
    input logic             a_busy,
    input logic             a_take,
    input logic [WIDTH-1:0] a_mail_data,
    input logic             a_mail_flag,
    input logic             b_post,
    input logic             b_busy,
    input logic             b_take,
    input logic [WIDTH-1:0] b_mail_data,
    input logic             b_mail_flag
);
    p_reset_clear_r1: assert property (@(posedge clk_a) disable iff (!rst_n)
        $rose(rst_n) |-> (!a_busy && !a_mail_flag && a_mail_data == '0));

    p_hold_mail_r2: assert property (@(posedge clk_b) disable iff (!rst_n)
        (b_mail_flag && !b_take) |=> (b_mail_flag && $stable(b_mail_data)));

    p_hold_mail_r3: assert property (@(posedge clk_a) disable iff (!rst_n)
        (a_mail_flag && !a_take) |=> (a_mail_flag && $stable(a_mail_data)));

    p_busy_after_post_r4: assert property (@(posedge clk_a) disable iff (!rst_n)
        (a_post && !a_busy) |=> a_busy);

    p_busy_covers_flag_r4: assert property (@(posedge clk_b) disable iff (!rst_n)
        b_mail_flag |-> a_busy);

    p_take_clears_b_r6: assert property (@(posedge clk_b) disable iff (!rst_n)
        (b_mail_flag && b_take) |=> !b_mail_flag);

    p_take_clears_a_r6: assert property (@(posedge clk_a) disable iff (!rst_n)
        (a_mail_flag && a_take) |=> !a_mail_flag);

    p_busy_after_post_b_r8: assert property (@(posedge clk_b) disable iff (!rst_n)
        (b_post && !b_busy) |=> b_busy);
endmodule

bind xmbox_pair xmbox_pair_chk #(.WIDTH(WIDTH)) u_chk (
    .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n),
    .a_post(a_post), .a_busy(a_busy), .a_take(a_take),
    .a_mail_data(a_mail_data), .a_mail_flag(a_mail_flag),
    .b_post(b_post), .b_busy(b_busy), .b_take(b_take),
    .b_mail_data(b_mail_data), .b_mail_flag(b_mail_flag)
);

// File: tb/xmbox_pair_test.sv
`timescale 1ns/1ps
module xmbox_pair_test;
    localparam int W = 36;

    logic         clk_a = 1'b0, clk_b = 1'b0, rst_n = 1'b0;
    logic         a_post = 1'b0, b_post = 1'b0, a_take = 1'b0, b_take = 1'b0;
    logic [W-1:0] a_post_data = '0, b_post_data = '0;
    logic         a_busy, b_busy, a_mail_flag, b_mail_flag;
    logic [W-1:0] a_mail_data, b_mail_data;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk_a = ~clk_a;   // 200 MHz
    always #3.5 clk_b = ~clk_b;   // unrelated clock

    xmbox_pair #(.WIDTH(W), .SYNC(2)) uut (
        .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n),
        .a_post(a_post), .a_post_data(a_post_data), .a_busy(a_busy),
        .a_take(a_take), .a_mail_data(a_mail_data), .a_mail_flag(a_mail_flag),
        .b_post(b_post), .b_post_data(b_post_data), .b_busy(b_busy),
        .b_take(b_take), .b_mail_data(b_mail_data), .b_mail_flag(b_mail_flag)
    );

    typedef struct packed {
        logic         from_b;   // 0: A posts to B, 1: B posts to A
        logic [W-1:0] word;
    } vec_t;

    localparam vec_t VECS [0:5] = '{
        '{1'b0, 36'h1_2345_6789},
        '{1'b1, 36'hA_BCDE_F012},
        '{1'b0, 36'hF_FFFF_FFFF},
        '{1'b1, 36'h0_0000_0000},
        '{1'b0, 36'h5_5555_5555},
        '{1'b1, 36'hA_AAAA_AAAA}
    };

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick_tx(input bit from_b);
        if (from_b) @(negedge clk_b); else @(negedge clk_a);
    endtask

    task automatic tick_rx(input bit from_b);
        if (from_b) @(negedge clk_a); else @(negedge clk_b);
    endtask

    function automatic logic rx_flag(input bit from_b);
        return from_b ? a_mail_flag : b_mail_flag;
    endfunction

    function automatic logic [W-1:0] rx_data(input bit from_b);
        return from_b ? a_mail_data : b_mail_data;
    endfunction

    function automatic logic tx_busy(input bit from_b);
        return from_b ? b_busy : a_busy;
    endfunction

    task automatic post(input bit from_b, input logic [W-1:0] d);
        tick_tx(from_b);
        if (from_b) begin b_post = 1'b1; b_post_data = d; end
        else        begin a_post = 1'b1; a_post_data = d; end
        tick_tx(from_b);
        a_post = 1'b0; b_post = 1'b0;
    endtask

    task automatic take(input bit from_b);
        tick_rx(from_b);
        if (from_b) a_take = 1'b1; else b_take = 1'b1;
        tick_rx(from_b);
        a_take = 1'b0; b_take = 1'b0;
    endtask

    task automatic wait_flag(input bit from_b, output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 12 && !seen; i++) begin
            tick_rx(from_b);
            seen = rx_flag(from_b);
        end
    endtask

    task automatic wait_idle(input bit from_b, output bit idle);
        idle = 1'b0;
        for (int i = 0; i < 12 && !idle; i++) begin
            tick_tx(from_b);
            idle = !tx_busy(from_b);
        end
    endtask

    initial begin
        bit ok;
        repeat (3) @(negedge clk_a);
        // R1: reset state
        check("R1 a_busy", W'(a_busy), '0);
        check("R1 b_busy", W'(b_busy), '0);
        check("R1 a_mail_flag", W'(a_mail_flag), '0);
        check("R1 b_mail_flag", W'(b_mail_flag), '0);
        check("R1 a_mail_data", a_mail_data, '0);
        check("R1 b_mail_data", b_mail_data, '0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk_b);
        check("R1 idle after release", W'({a_busy, b_busy, a_mail_flag, b_mail_flag}), '0);

        // Vector walk: R2 / R3 delivery, R4 busy, R6 clear and release
        foreach (VECS[k]) begin
            post(VECS[k].from_b, VECS[k].word);
            check(VECS[k].from_b ? "R4 b_busy after post" : "R4 a_busy after post",
                  W'(tx_busy(VECS[k].from_b)), W'(1));
            wait_flag(VECS[k].from_b, ok);
            check(VECS[k].from_b ? "R3 flag" : "R2 flag", W'(ok), W'(1));
            check(VECS[k].from_b ? "R3 data" : "R2 data", rx_data(VECS[k].from_b), VECS[k].word);
            check("R4 busy while flag", W'(tx_busy(VECS[k].from_b)), W'(1));
            take(VECS[k].from_b);
            check("R6 flag cleared", W'(rx_flag(VECS[k].from_b)), '0);
            wait_idle(VECS[k].from_b, ok);
            check("R6 busy released", W'(ok), W'(1));
        end

        // R5: second post while busy is dropped
        post(1'b0, 36'h0_DEAD_BEEF);
        post(1'b0, 36'h0_1111_2222);
        wait_flag(1'b0, ok);
        check("R5 flag", W'(ok), W'(1));
        check("R5 first word kept", b_mail_data, 36'h0_DEAD_BEEF);
        take(1'b0);
        wait_idle(1'b0, ok);
        check("R5 busy released", W'(ok), W'(1));
        wait_flag(1'b0, ok);
        check("R5 no second flag", W'(ok), '0);
        check("R5 data unchanged", b_mail_data, 36'h0_DEAD_BEEF);

        // R7: take with no mail has no effect
        take(1'b0);
        repeat (8) @(negedge clk_b);
        check("R7 b_mail_flag stays low", W'(b_mail_flag), '0);
        check("R7 a_busy stays low", W'(a_busy), '0);
        take(1'b1);
        repeat (8) @(negedge clk_a);
        check("R7 a_mail_flag stays low", W'(a_mail_flag), '0);
        check("R7 b_busy stays low", W'(b_busy), '0);

        // R8: both directions at once
        @(negedge clk_a);
        a_post = 1'b1; a_post_data = 36'h9_8765_4321;
        b_post = 1'b1; b_post_data = 36'h3_C3C3_C3C3;
        fork
            begin @(negedge clk_a); a_post = 1'b0; end
            begin @(negedge clk_b); b_post = 1'b0; end
        join
        repeat (12) @(negedge clk_b);
        check("R8 b_mail_flag", W'(b_mail_flag), W'(1));
        check("R8 a_mail_flag", W'(a_mail_flag), W'(1));
        check("R8 b_mail_data", b_mail_data, 36'h9_8765_4321);
        check("R8 a_mail_data", a_mail_data, 36'h3_C3C3_C3C3);
        take(1'b0);
        take(1'b1);
        repeat (12) @(negedge clk_b);
        check("R8 all idle", W'({a_busy, b_busy, a_mail_flag, b_mail_flag}), '0);

        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule